// File: doc/BRIEF.md
# Interrupt Controller Operation Command Decoder

This block is the register slice of a legacy-style programmable interrupt controller that handles the third operation command byte written to the command port. It decodes each byte write, keeps the special-mask-mode flag, remembers which status vector a read of the command port should return, and arms a one-shot poll. Initialization sequencing, cascading and end-of-interrupt handling belong to other blocks.

A CPU read of the port returns one of three things. It returns the pending-request vector or the in-service vector, whichever was last selected. If a poll is armed, it returns an encoded byte that names the highest-priority unmasked pending line. A poll read that finds a request also raises a one-cycle acknowledge, which carries the level number to the in-service logic. The read data and the acknowledge are combinational on the read strobe. Every state change happens at the clock edge that ends the strobe.

Top module: `ocw_port`

## Requirements
- R1: After the synchronous active-high reset, the special-mask-mode flag is 0, no poll is armed and a port read returns the request vector.
- R2: A write is decoded only when data bits 4:3 equal binary 01 and data bit 7 is 0. Any other write leaves the flag, the read selection and the poll state unchanged.
- R3: A decoded write with bit 5 set loads the special-mask-mode flag from bit 6, so bit 6 = 1 sets it and bit 6 = 0 clears it. With bit 5 clear, the flag keeps its value whatever bit 6 holds.
- R4: A decoded write with bit 1 set selects the request vector when bit 0 = 0 and the in-service vector when bit 0 = 1. With bit 1 clear, the selection is kept and bit 0 is ignored.
- R5: The selected vector is returned on every read, reflecting its present value, without any further write.
- R6: A decoded write with bit 2 set arms a poll. The next read returns 8'h80 OR the lowest-numbered line that is requesting and not masked (line 0 has the highest priority, and the number sits in bits 2:0). If no such line exists, the read returns 8'h00.
- R7: The poll is disarmed by the read that consumes it. Later reads return the selected vector again.
- R8: A poll read that finds a pending line drives poll_ack high for that read cycle, with poll_ack_lvl equal to the line number. No other read raises poll_ack.
- R9: An initialization-complete pulse clears the flag and the poll and selects the request vector. It overrides a command write in the same cycle.
- R10: A read in the same cycle as a decoded write returns the result under the state from before that write. The write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Command port write strobe, one cycle per write |
| cpu_rd | input | 1 | Command port read strobe, one cycle per read |
| cpu_wdata | input | 8 | Write data byte |
| init_done | input | 1 | Initialization-complete pulse |
| irq_req | input | 8 | Pending-request vector |
| irq_svc | input | 8 | In-service vector |
| irq_mask | input | 8 | Mask vector, 1 masks the line |
| cpu_rdata | output | 8 | Read data byte |
| smm_flag | output | 1 | Special-mask-mode flag |
| poll_ack | output | 1 | Poll acknowledge pulse |
| poll_ack_lvl | output | 3 | Acknowledged line number |

## Verification
A wrong read selection shows up as the wrong vector on the very next read. A stuck or lost poll shows up as an encoded byte where a vector was expected, or the reverse. Both are caught within one read of the disturbing write. A corrupted flag is visible on smm_flag one cycle after the write. The bench therefore interleaves reads with every kind of write, including malformed and overlapping ones, and changes the vectors between reads so that a stale or mis-prioritised result cannot match by chance.

// File: rtl/ocw_pkg.sv
package ocw_pkg;

    localparam int DATA_W     = 8;
    localparam int NUM_LINES  = 8;

    // Field positions of the command byte (decoded by the controller's bus side)
    localparam int F_RSVD     = 7;
    localparam int F_SMM_VAL  = 6;
    localparam int F_SMM_EN   = 5;
    localparam int F_KEY_HI   = 4;
    localparam int F_KEY_LO   = 3;
    localparam int F_POLL     = 2;
    localparam int F_SEL_EN   = 1;
    localparam int F_SEL_SVC  = 0;
    localparam logic [1:0] CMD_KEY = 2'b01;

    // Poll byte: flag bit marks a found request
    localparam int P_FOUND    = 7;

    typedef enum logic {
        RD_REQ = 1'b0,
        RD_SVC = 1'b1
    } rd_sel_e;

    typedef struct packed {
        logic    valid;
        logic    smm_wr;
        logic    smm_val;
        logic    poll;
        logic    sel_wr;
        rd_sel_e sel;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [DATA_W-1:0] d, input logic wr);
        cmd_t c;
        c.valid   = wr && (d[F_KEY_HI:F_KEY_LO] == CMD_KEY) && !d[F_RSVD];
        c.smm_wr  = c.valid && d[F_SMM_EN];
        c.smm_val = d[F_SMM_VAL];
        c.poll    = c.valid && d[F_POLL];
        c.sel_wr  = c.valid && d[F_SEL_EN];
        c.sel     = d[F_SEL_SVC] ? RD_SVC : RD_REQ;
        return c;
    endfunction

endpackage

// File: rtl/ocw_state.sv
module ocw_state
    import ocw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    init_done,
    input  logic    rd_en,
    input  cmd_t    cmd,
    output logic    smm,
    output logic    poll_armed,
    output rd_sel_e sel
);

    logic    smm_q, poll_q;
    rd_sel_e sel_q;

    always_ff @(posedge clk) begin
        if (rst || init_done) begin
            smm_q  <= 1'b0;
            poll_q <= 1'b0;
            sel_q  <= RD_REQ;
        end else begin
            if (cmd.smm_wr)
                smm_q <= cmd.smm_val;
            if (cmd.sel_wr)
                sel_q <= cmd.sel;
            if (cmd.poll)
                poll_q <= 1'b1;
            else if (rd_en)
                poll_q <= 1'b0;
        end
    end

    assign smm        = smm_q;
    assign poll_armed = poll_q;
    assign sel        = sel_q;

    // R9
    a_r9_init_clears: assert property (@(posedge clk) disable iff (rst)
        init_done |=> (!smm && !poll_armed && sel == RD_REQ));

    // R3
    a_r3_smm_hold: assert property (@(posedge clk) disable iff (rst)
        (!init_done && !cmd.smm_wr) |=> $stable(smm));

    // R4
    a_r4_sel_hold: assert property (@(posedge clk) disable iff (rst)
        (!init_done && !cmd.sel_wr) |=> $stable(sel));

    // R7
    a_r7_poll_clears: assert property (@(posedge clk) disable iff (rst)
        (!init_done && rd_en && poll_armed && !cmd.poll) |=> !poll_armed);

endmodule

// File: rtl/ocw_poll_enc.sv
module ocw_poll_enc #(
    parameter int LINES = ocw_pkg::NUM_LINES,
    localparam int LVL_W = $clog2(LINES)
) (
    input  logic [LINES-1:0] pend,
    output logic             found,
    output logic [LVL_W-1:0] lvl
);

    always_comb begin
        found = 1'b0;
        lvl   = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (pend[i]) begin
                found = 1'b1;
                lvl   = LVL_W'(i);
            end
        end
    end

endmodule

// File: rtl/ocw_read_mux.sv
module ocw_read_mux
    import ocw_pkg::*;
#(
    parameter int LINES = NUM_LINES,
    localparam int LVL_W = $clog2(LINES)
) (
    input  rd_sel_e          sel,
    input  logic             poll_armed,
    input  logic             found,
    input  logic [LVL_W-1:0] lvl,
    input  logic [LINES-1:0] req,
    input  logic [LINES-1:0] svc,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] poll_byte;

    always_comb begin
        poll_byte = '0;
        if (found) begin
            poll_byte[P_FOUND]   = 1'b1;
            poll_byte[LVL_W-1:0] = lvl;
        end
    end

    always_comb begin
        if (poll_armed)
            rdata = poll_byte;
        else if (sel == RD_SVC)
            rdata = DATA_W'(svc);
        else
            rdata = DATA_W'(req);
    end

endmodule

// File: rtl/ocw_port.sv
module ocw_port
    import ocw_pkg::*;
#(
    parameter int LINES = NUM_LINES,
    localparam int LVL_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              init_done,
    input  logic [LINES-1:0]  irq_req,
    input  logic [LINES-1:0]  irq_svc,
    input  logic [LINES-1:0]  irq_mask,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              smm_flag,
    output logic              poll_ack,
    output logic [LVL_W-1:0]  poll_ack_lvl
);

    cmd_t             cmd;
    rd_sel_e          sel;
    logic             poll_armed;
    logic [LINES-1:0] pend;
    logic             hit_found;
    logic [LVL_W-1:0] hit_lvl;

    assign cmd  = decode_cmd(cpu_wdata, cpu_wr);
    assign pend = irq_req & ~irq_mask;

    ocw_state u_state (
        .clk        (clk),
        .rst        (rst),
        .init_done  (init_done),
        .rd_en      (cpu_rd),
        .cmd        (cmd),
        .smm        (smm_flag),
        .poll_armed (poll_armed),
        .sel        (sel)
    );

    ocw_poll_enc #(.LINES(LINES)) u_enc (
        .pend  (pend),
        .found (hit_found),
        .lvl   (hit_lvl)
    );

    ocw_read_mux #(.LINES(LINES)) u_mux (
        .sel        (sel),
        .poll_armed (poll_armed),
        .found      (hit_found),
        .lvl        (hit_lvl),
        .req        (irq_req),
        .svc        (irq_svc),
        .rdata      (cpu_rdata)
    );

    assign poll_ack     = cpu_rd && poll_armed && hit_found;
    assign poll_ack_lvl = poll_ack ? hit_lvl : '0;

    // R6: encoder names a line that really is pending
    a_r6_level_pending: assert property (@(posedge clk) disable iff (rst)
        hit_found |-> pend[hit_lvl]);

    // R6: no pending line below the named one
    a_r6_lowest: assert property (@(posedge clk) disable iff (rst)
        hit_found |-> ((pend & ~({LINES{1'b1}} << hit_lvl)) == '0));

    // R6: empty poll returns zero
    a_r6_empty_byte: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && poll_armed && (pend == '0)) |-> (cpu_rdata == '0));

    // R8: acknowledge agrees with the byte on the bus
    a_r8_ack_matches_rdata: assert property (@(posedge clk) disable iff (rst)
        poll_ack |-> (cpu_rdata[P_FOUND] && cpu_rdata[LVL_W-1:0] == poll_ack_lvl));

endmodule

// File: tb/ocw_port_bench.sv
module ocw_port_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0] data;
        logic       ack;
        logic [2:0] lvl;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_wr = 1'b0;
    logic       cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic       init_done = 1'b0;
    logic [7:0] irq_req = 8'h00;
    logic [7:0] irq_svc = 8'h00;
    logic [7:0] irq_mask = 8'h00;
    logic [7:0] cpu_rdata;
    logic       smm_flag;
    logic       poll_ack;
    logic [2:0] poll_ack_lvl;

    int n_checks = 0;
    int n_fail   = 0;

    exp_t  exp_q[$];
    string tag_q[$];

    // bench model of the block state
    logic m_smm  = 1'b0;
    logic m_svc  = 1'b0;
    logic m_poll = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ocw_port u_ocw_port (
        .clk          (clk),
        .rst          (rst),
        .cpu_wr       (cpu_wr),
        .cpu_rd       (cpu_rd),
        .cpu_wdata    (cpu_wdata),
        .init_done    (init_done),
        .irq_req      (irq_req),
        .irq_svc      (irq_svc),
        .irq_mask     (irq_mask),
        .cpu_rdata    (cpu_rdata),
        .smm_flag     (smm_flag),
        .poll_ack     (poll_ack),
        .poll_ack_lvl (poll_ack_lvl)
    );

    // one bus cycle: any combination of write, read and init pulse
    task automatic bus_cycle(input logic wr, input logic [7:0] wd, input logic rd,
                             input logic ini, input string tag);
        exp_t e;
        logic [7:0] pend;
        logic ok;
        e = '0;
        if (rd) begin
            if (m_poll) begin
                pend = irq_req & ~irq_mask;
                for (int i = 7; i >= 0; i--) begin
                    if (pend[i]) begin
                        e.ack  = 1'b1;
                        e.lvl  = 3'(i);
                    end
                end
                e.data = e.ack ? {5'b10000, e.lvl} : 8'h00;
            end else begin
                e.data = m_svc ? irq_svc : irq_req;
            end
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
        @(posedge clk); #1;
        cpu_wr = wr; cpu_wdata = wd; cpu_rd = rd; init_done = ini;
        // model update for the edge that ends this cycle
        ok = wr && (wd[4:3] == 2'b01) && !wd[7];
        if (ini) begin
            m_smm = 1'b0; m_svc = 1'b0; m_poll = 1'b0;
        end else begin
            if (ok && wd[5]) m_smm = wd[6];
            if (ok && wd[1]) m_svc = wd[0];
            if (ok && wd[2]) m_poll = 1'b1;
            else if (rd)     m_poll = 1'b0;
        end
        @(posedge clk); #1;
        cpu_wr = 1'b0; cpu_rd = 1'b0; init_done = 1'b0; cpu_wdata = 8'h00;
    endtask

    task automatic write_cmd(input logic [7:0] d, input string tag);
        bus_cycle(1'b1, d, 1'b0, 1'b0, tag);
    endtask

    task automatic read_port(input string tag);
        bus_cycle(1'b0, 8'h00, 1'b1, 1'b0, tag);
    endtask

    task automatic check_smm(input string tag);
        @(negedge clk);
        n_checks++;
        if (smm_flag !== m_smm) begin
            n_fail++;
            $display("FAIL %s smm_flag actual=%b expected=%b", tag, smm_flag, m_smm);
        end
    endtask

    // monitor: compares each read with the head of the scoreboard
    always @(negedge clk) begin
        if (cpu_rd) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL unexpected read actual=%02h expected=none", cpu_rdata);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_checks++;
                if (cpu_rdata !== e.data || poll_ack !== e.ack ||
                    (e.ack && poll_ack_lvl !== e.lvl)) begin
                    n_fail++;
                    $display("FAIL %s read actual=%02h ack=%b lvl=%0d expected=%02h ack=%b lvl=%0d",
                             t, cpu_rdata, poll_ack, poll_ack_lvl, e.data, e.ack, e.lvl);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        irq_req = 8'h28; irq_svc = 8'h04; irq_mask = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        check_smm("R1");
        read_port("R1");

        // R4 select in-service, R5 repeated reads follow the vector
        write_cmd(8'h0B, "R4");
        read_port("R4");
        read_port("R5");
        irq_svc = 8'h10;
        read_port("R5");
        // R4 bit 1 clear keeps selection
        write_cmd(8'h08, "R4");
        read_port("R4");
        write_cmd(8'h0A, "R4");
        read_port("R4");
        write_cmd(8'h09, "R4");
        read_port("R4");

        // R3 special mask mode
        write_cmd(8'h68, "R3");
        check_smm("R3");
        write_cmd(8'h48, "R3");
        check_smm("R3");
        write_cmd(8'h28, "R3");
        check_smm("R3");

        // R2 malformed writes ignored
        write_cmd(8'h73, "R2");
        check_smm("R2");
        read_port("R2");
        write_cmd(8'hEB, "R2");
        check_smm("R2");
        read_port("R2");
        write_cmd(8'h14, "R2");
        read_port("R2");

        // R6 / R8 poll with masked lower lines, then R7 auto clear
        irq_mask = 8'h20;
        write_cmd(8'h0C, "R6");
        read_port("R6_R8");
        read_port("R7");
        irq_req = 8'h81; irq_mask = 8'h00;
        write_cmd(8'h0C, "R6");
        read_port("R6_R8");
        irq_req = 8'h80;
        write_cmd(8'h0C, "R6");
        read_port("R6_R8");
        irq_mask = 8'hFF;
        write_cmd(8'h0C, "R6");
        read_port("R6_R8");
        read_port("R7");
        irq_mask = 8'h00; irq_req = 8'h5A; irq_svc = 8'hC3;

        // R9 init clears, and overrides a concurrent write
        write_cmd(8'h6F, "R9");
        bus_cycle(1'b0, 8'h00, 1'b0, 1'b1, "R9");
        check_smm("R9");
        read_port("R9");
        bus_cycle(1'b1, 8'h6F, 1'b0, 1'b1, "R9");
        check_smm("R9");
        read_port("R9");

        // R10 concurrent write and read
        bus_cycle(1'b1, 8'h0B, 1'b1, 1'b0, "R10");
        read_port("R10");
        bus_cycle(1'b1, 8'h0C, 1'b1, 1'b0, "R10");
        read_port("R10");
        read_port("R10");

        repeat (3) @(posedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule